// File: doc/BRIEF.md
# Half-Integer Refresh and Sound Rate Divider

This block turns a 3.6864 MHz input clock into the refresh/sound rate tick. It divides by 41.5, which gives a rate of about 88.8 kHz. A half-integer ratio cannot come from a single counter limit, so the divider alternates between a short period of 41 input clocks and a long period of 42. Any two back-to-back periods therefore cover exactly 83 clocks. A one-cycle `refresh_tick` marks the end of every period.

A two-bit sub-divider counts those periods. It raises `sound_tick` on every fourth one, because the refresh rate is by definition four times the sound sample rate.

A mode input decides whether an external enable pin gates the divider. When gating is selected and the pin is low, both counters freeze and no ticks come out. When the pin returns high, counting resumes from the frozen state.

Top module: `refsnd_divider`

## Requirements
- R1: While `rst_n` is low both outputs are 0. Reset clears both counters and selects the short (41-cycle) phase. With counting allowed on every edge, the first `refresh_tick` is high in the cycle after the 41st rising edge following reset release.
- R2: `refresh_tick` is high for exactly one cycle at the end of each divided period.
- R3: Successive periods alternate 41 and 42 counted edges, starting with 41. The gaps between three consecutive ticks of an ungated run therefore add up to 83 cycles.
- R4: `sound_tick` is high for one cycle, in the same cycle as every fourth `refresh_tick` counted from reset. It is never high without `refresh_tick`.
- R5: With `gate_sel` = 0 the divider counts on every edge, and `ext_en` has no effect on either output.
- R6: With `gate_sel` = 1, an edge that sees `ext_en` = 0 is not counted. Both counters keep their values, and no tick appears in the following cycle. Counting resumes from the held state once `ext_en` is 1 again.
- R7: With `gate_sel` = 1 and `ext_en` = 1 the divider behaves exactly as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider input clock (3.6864 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_sel | input | 1 | 1 = `ext_en` gates counting, 0 = free running |
| ext_en | input | 1 | External count enable, used only when `gate_sel` = 1 |
| refresh_tick | output | 1 | One-cycle pulse per divided period (41/42 alternating) |
| sound_tick | output | 1 | One-cycle pulse on every fourth refresh tick |

## Verification
The bench targets the 41/42 alternation and the phase after reset. A design that starts in the long phase, or that does not alternate, puts the first tick one cycle late or breaks the 83-cycle pair sum. While free running, `ext_en` is toggled at random. A divider that wrongly obeys the pin in that mode loses edges, and its ticks drift from the model.

Under gating, single-cycle and long enable drops check that the count and the phase both hold and then resume exactly. A counter that restarts, or that skips the held edge, shifts every later tick. The fourth-tick alignment of `sound_tick` is followed across gated stretches, which exposes a sub-counter that advances on uncounted edges or is off by one.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

   // Phase of the alternating divider: short period first after reset.
   typedef enum logic {
      PH_SHORT = 1'b0,
      PH_LONG  = 1'b1
   } hdiv_phase_e;

   // Bits needed to hold values 0 .. n-1 (at least one bit).
   function automatic int unsigned bits_for(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/hdiv_gate.sv
module hdiv_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_sel,
   input  logic ext_en,
   output logic run
);

   // Count unless gating is selected and the enable pin is low.
   assign run = ~gate_sel | ext_en;

   AST_FREE_RUN_IGNORES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_sel |-> run); // R5

   AST_GATED_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      gate_sel |-> (run == ext_en)); // R7

endmodule

// File: rtl/hdiv_period.sv
module hdiv_period
   import hdiv_pkg::*;
#(
   parameter int unsigned SHORT_CYCLES = 41
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic wrap,
   output logic tick_o
);

   localparam int unsigned LONG_CYCLES = SHORT_CYCLES + 1;
   localparam int unsigned CNT_W       = bits_for(LONG_CYCLES);
   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_CYCLES - 1);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_CYCLES - 1);

   if (SHORT_CYCLES < 2) begin : g_bad_short
      $error("hdiv_period: SHORT_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   hdiv_phase_e      phase_q;
   logic [CNT_W-1:0] last_cnt;

   // Terminal count depends on which half of the 83-cycle pair is running.
   assign last_cnt = (phase_q == PH_LONG) ? LAST_LONG : LAST_SHORT;
   assign wrap     = run && (cnt_q == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= PH_SHORT;
         tick_o  <= 1'b0;
      end else begin
         tick_o <= wrap;
         if (wrap) begin
            cnt_q   <= '0;
            phase_q <= (phase_q == PH_LONG) ? PH_SHORT : PH_LONG;
         end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST_LONG); // R3

   AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o); // R2

   AST_PHASE_FLIPS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> (phase_q != $past(phase_q))); // R3

   AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(cnt_q) && $stable(phase_q) && !tick_o)); // R6

endmodule

// File: rtl/hdiv_subdiv.sv
module hdiv_subdiv
   import hdiv_pkg::*;
#(
   parameter int unsigned SUB_RATIO = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wrap,
   input  logic ref_tick_i,
   output logic snd_o
);

   localparam int unsigned SUB_W = bits_for(SUB_RATIO);
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_RATIO - 1);

   if (SUB_RATIO < 2) begin : g_bad_ratio
      $error("hdiv_subdiv: SUB_RATIO must be at least 2");
   end

   logic [SUB_W-1:0] sub_q;
   logic             sub_end;
   logic [SUB_W-1:0] sub_next;

   assign sub_end = (sub_q == SUB_LAST);

   if ((SUB_RATIO & (SUB_RATIO - 1)) == 0) begin : g_pow2
      // Power-of-two ratio wraps naturally.
      assign sub_next = sub_q + 1'b1;
   end else begin : g_modulo
      assign sub_next = sub_end ? '0 : sub_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= '0;
         snd_o <= 1'b0;
      end else begin
         snd_o <= wrap && sub_end;
         if (wrap) begin
            sub_q <= sub_next;
         end
      end
   end

   AST_SOUND_WITH_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
      snd_o |-> ref_tick_i); // R4

   AST_SOUND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      snd_o |=> !snd_o); // R4

   AST_SUB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(sub_q)); // R6

endmodule

// File: rtl/refsnd_divider.sv
module refsnd_divider #(
   parameter int unsigned SHORT_CYCLES = 41,
   parameter int unsigned SUB_RATIO    = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_sel,
   input  logic ext_en,
   output logic refresh_tick,
   output logic sound_tick
);

   logic run;
   logic wrap;

   hdiv_gate gate_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_sel (gate_sel),
      .ext_en   (ext_en),
      .run      (run)
   );

   hdiv_period #(
      .SHORT_CYCLES (SHORT_CYCLES)
   ) period_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .wrap   (wrap),
      .tick_o (refresh_tick)
   );

   hdiv_subdiv #(
      .SUB_RATIO (SUB_RATIO)
   ) subdiv_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wrap       (wrap),
      .ref_tick_i (refresh_tick),
      .snd_o      (sound_tick)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (!refresh_tick && !sound_tick)); // R1

   AST_GATED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_sel && !ext_en) |=> (!refresh_tick && !sound_tick)); // R6

endmodule

// File: tb/refsnd_divider_tb_top.sv
`timescale 1ns/1ps
module refsnd_divider_tb_top;

   localparam int SHORT_P = 41;
   localparam int SUB_P   = 4;

   typedef struct {
      logic  ref_t;
      logic  snd_t;
      logic  sp;
      string tag;
   } exp_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic gate_sel = 1'b0;
   logic ext_en = 1'b0;
   logic refresh_tick;
   logic sound_tick;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   exp_item_t q[$];

   // Bench model state (counted edges in current period, phase, sub count)
   int m_cnt = 0;
   int m_ph  = 0;
   int m_sc  = 0;

   always #2 clk = ~clk;

   refsnd_divider dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .gate_sel     (gate_sel),
      .ext_en       (ext_en),
      .refresh_tick (refresh_tick),
      .sound_tick   (sound_tick)
   );

   // Driver: applies inputs at a falling edge, pushes expectation for next rise.
   task automatic step(input logic g, input logic e, input bit sp, input string tag);
      exp_item_t it;
      gate_sel = g;
      ext_en   = e;
      it.ref_t = 1'b0;
      it.snd_t = 1'b0;
      it.sp    = sp;
      it.tag   = tag;
      if (!g || e) begin
         m_cnt++;
         if (m_cnt == SHORT_P + m_ph) begin
            it.ref_t = 1'b1;
            m_cnt    = 0;
            m_ph     = 1 - m_ph;
            m_sc++;
            if (m_sc == SUB_P) begin
               it.snd_t = 1'b1;
               m_sc     = 0;
            end
         end
      end
      q.push_back(it);
      @(negedge clk);
   endtask

   // Monitor: samples 1 ns after each rising edge and compares.
   int  gap = 0;
   int  prev_gap = 0;
   bit  prev_ok = 0;
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_item_t it;
            it = q.pop_front();
            gap++;
            checks++;
            if (refresh_tick !== it.ref_t) begin
               fails++;
               $display("FAIL %s/R2 refresh_tick got %b expected %b at %0t",
                        it.tag, refresh_tick, it.ref_t, $time);
            end
            checks++;
            if (sound_tick !== it.snd_t) begin
               fails++;
               $display("FAIL %s/R4 sound_tick got %b expected %b at %0t",
                        it.tag, sound_tick, it.snd_t, $time);
            end
            if (!it.sp) begin
               prev_ok = 0;
            end
            if (refresh_tick === 1'b1) begin
               if (it.sp && prev_ok) begin
                  // R3: two consecutive free-running periods span 83 cycles
                  checks++;
                  if (prev_gap + gap != 2 * SHORT_P + 1) begin
                     fails++;
                     $display("FAIL R3 pair span got %0d expected %0d",
                              prev_gap + gap, 2 * SHORT_P + 1);
                  end
               end
               prev_gap = gap;
               prev_ok  = it.sp;
               gap      = 0;
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog expired got running expected finished");
      finish_run();
   end

   initial begin
      // R1: outputs quiet while reset held, even with counting allowed
      repeat (3) @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         checks++;
         if (refresh_tick !== 1'b0 || sound_tick !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs got %b%b expected 00",
                     refresh_tick, sound_tick);
         end
         @(negedge clk);
      end
      rst_n = 1'b1;

      // R1: first period is the short one (tick after 41st edge)
      for (int i = 0; i < SHORT_P + 2; i++) step(1'b0, 1'b0, 1'b1, "R1");
      // R5: free running, pin toggling must not matter
      for (int i = 0; i < 900; i++) step(1'b0, 1'($urandom_range(0, 1)), 1'b1, "R5");
      // R7: gated mode with pin held high behaves as free running
      for (int i = 0; i < 400; i++) step(1'b1, 1'b1, 1'b1, "R7");
      // R6: random pin drops while gating
      for (int i = 0; i < 1500; i++) step(1'b1, 1'($urandom_range(0, 1)), 1'b0, "R6");
      // R6: single-cycle drops
      for (int i = 0; i < 300; i++) step(1'b1, (i % 7) != 3, 1'b0, "R6");
      // R6: long hold, then resume from held state
      for (int i = 0; i < 150; i++) step(1'b1, 1'b0, 1'b0, "R6");
      for (int i = 0; i < 400; i++) step(1'b1, 1'b1, 1'b0, "R6");
      // Back to free running; R3 spacing rechecked after first gap
      for (int i = 0; i < 400; i++) step(1'b0, 1'b0, 1'b1, "R3");

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule